// File: doc/BRIEF.md
# Banked Data Memory with Pointer Indirection

This unit is the data store of a small 8-bit controller, together with the logic that decides where each address goes. The 256-entry address space has a low window, below 40H, that every bank shares. Above that window it has three separate banks. Two locations hold no storage of their own. An access to 00H is forwarded to the address held in the first pointer at 01H. An access to 02H is forwarded to the address held in the second pointer at 03H. Only the second pointer's forwarding, and only for targets in the upper window, pays attention to the external bank selector.

The read port and the write port each carry their own address, so one cycle can perform a move from one location to another. Writes land on the clock edge. Reads are combinational from the stored state. The accumulator lives at 05H and its content is also driven out on its own port. If a single move names a pointer-forwarded location on both sides, the unit raises an error flag and does not perform the write.

Top module: `bdm_top`

## Requirements
- R1: After reset every location reads 00H and `accValue` is 00H.
- R2: A direct read or write, using any address other than 00H and 02H, always reaches bank 0, whatever `bankSel` holds. A write is visible on a read starting in the next cycle.
- R3: An access at 00H is forwarded to the bank 0 location named by the byte stored at 01H. `bankSel` has no effect on this path.
- R4: An access at 02H whose target, the byte stored at 03H, is below 40H reaches the shared low window, the same storage that a direct access reaches.
- R5: An access at 02H whose target is 40H or above reaches bank 1 when `bankSel` is 01H and bank 2 when `bankSel` is 02H. Each of these is storage separate from bank 0.
- R6: With any other `bankSel` value, including 00H, 03H and FFH, an upper-window access at 02H reaches bank 0.
- R7: When the pointer used by a forwarded access holds 00H or 02H, a read returns 00H and a write changes no location.
- R8: `accValue` shows the content of location 05H. It follows a write to 05H from the next cycle, whether that write was direct or forwarded.
- R9: When `rdEn` and `wrEn` are both high and both `rdAddr` and `wrAddr` are 00H or 02H, `bothIndErr` is high in that same cycle and no location is written. In every other case `bothIndErr` is low.
- R10: `rdData` is 00H whenever `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 8 | Read address |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 8 | Write address |
| wrData | input | 8 | Write data |
| bankSel | input | 8 | Bank selector applied to upper-window accesses through 02H |
| rdData | output | 8 | Combinational read data |
| accValue | output | 8 | Current content of location 05H |
| bothIndErr | output | 1 | A move named forwarded locations on both sides |

## Verification
A wrong bank choice or a wrong offset inside a bank shows up at the ports only later: the byte lands somewhere it should not, and a read through a different path sees the stray value or misses the expected one. The bench therefore keeps every write in a model and checks each read against that model, so such faults appear on the first later read of either location concerned. Pointer contents are ordinary memory, so corrupting one misdirects every later forwarded access. An accumulator fault appears on `accValue` one cycle after the write.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 8;
  localparam int NUM_BANKS  = 3;
  localparam int SHARED_TOP = 64;
  localparam int SPACE      = 1 << ADDR_W;
  localparam int UPPER      = SPACE - SHARED_TOP;
  localparam int DEPTH      = SPACE + (NUM_BANKS - 1) * UPPER;
  localparam int IDX_W      = $clog2(DEPTH);

  localparam logic [ADDR_W-1:0] IND0_ADDR = 8'h00;
  localparam logic [ADDR_W-1:0] PTR0_ADDR = 8'h01;
  localparam logic [ADDR_W-1:0] IND1_ADDR = 8'h02;
  localparam logic [ADDR_W-1:0] PTR1_ADDR = 8'h03;
  localparam logic [ADDR_W-1:0] ACC_ADDR  = 8'h05;

  typedef struct packed {
    logic             wrGo;
    logic [IDX_W-1:0] wrIdx;
    logic             rdGo;
    logic [IDX_W-1:0] rdIdx;
  } memStrobe_t;
endpackage

// File: rtl/bdm_resolve.sv
module bdm_resolve
  import bdm_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] bankSel,
  input  logic [ADDR_W-1:0] ptr0,
  input  logic [ADDR_W-1:0] ptr1,
  output logic [IDX_W-1:0]  idx,
  output logic              isVirt,
  output logic              reachable
);
  logic              viaPtr1;
  logic [ADDR_W-1:0] target;
  int                bank;
  int                idxInt;

  always_comb begin
    isVirt  = (addr == IND0_ADDR) || (addr == IND1_ADDR);
    viaPtr1 = (addr == IND1_ADDR);
    if (addr == IND0_ADDR)  target = ptr0;
    else if (viaPtr1)       target = ptr1;
    else                    target = addr;
    reachable = !(isVirt && ((target == IND0_ADDR) || (target == IND1_ADDR)));
    bank = 0;
    if (viaPtr1 && int'(target) >= SHARED_TOP &&
        int'(bankSel) >= 1 && int'(bankSel) < NUM_BANKS)
      bank = int'(bankSel);
    if (bank == 0) idxInt = int'(target);
    else           idxInt = SPACE + (bank - 1) * UPPER + (int'(target) - SHARED_TOP);
    idx = idxInt[IDX_W-1:0];
  end
endmodule

// File: rtl/bdm_ctrl.sv
module bdm_ctrl
  import bdm_pkg::*;
(
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] bankSel,
  input  logic [ADDR_W-1:0] ptr0,
  input  logic [ADDR_W-1:0] ptr1,
  output memStrobe_t        strobe,
  output logic              bothIndErr
);
  localparam int NPORT = 2;  // 0 = read side, 1 = write side

  logic [ADDR_W-1:0] portAddr [NPORT];
  logic [IDX_W-1:0]  portIdx  [NPORT];
  logic              portVirt [NPORT];
  logic              portOk   [NPORT];

  assign portAddr[0] = rdAddr;
  assign portAddr[1] = wrAddr;

  for (genvar p = 0; p < NPORT; p++) begin : g_res
    bdm_resolve res_i (
      .addr     (portAddr[p]),
      .bankSel  (bankSel),
      .ptr0     (ptr0),
      .ptr1     (ptr1),
      .idx      (portIdx[p]),
      .isVirt   (portVirt[p]),
      .reachable(portOk[p])
    );
  end

  always_comb begin
    bothIndErr   = rdEn && wrEn && portVirt[0] && portVirt[1];
    strobe.rdGo  = rdEn && portOk[0];
    strobe.rdIdx = portIdx[0];
    strobe.wrGo  = wrEn && portOk[1] && !bothIndErr;
    strobe.wrIdx = portIdx[1];
  end
endmodule

// File: rtl/bdm_dpath.sv
module bdm_dpath
  import bdm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ptr0,
  output logic [DATA_W-1:0] ptr1,
  output logic [DATA_W-1:0] acc
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.wrGo) begin
      mem[strobe.wrIdx] <= wrData;
    end
  end

  assign rdData = strobe.rdGo ? mem[strobe.rdIdx] : '0;
  assign ptr0   = mem[int'(PTR0_ADDR)];
  assign ptr1   = mem[int'(PTR1_ADDR)];
  assign acc    = mem[int'(ACC_ADDR)];
endmodule

// File: rtl/bdm_top.sv
module bdm_top
  import bdm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] bankSel,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] accValue,
  output logic              bothIndErr
);
  memStrobe_t        strobe;
  logic [DATA_W-1:0] ptr0Val;
  logic [DATA_W-1:0] ptr1Val;

  bdm_ctrl ctrl_i (
    .rdEn      (rdEn),
    .rdAddr    (rdAddr),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .bankSel   (bankSel),
    .ptr0      (ptr0Val),
    .ptr1      (ptr1Val),
    .strobe    (strobe),
    .bothIndErr(bothIndErr)
  );

  bdm_dpath dpath_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(wrData),
    .rdData(rdData),
    .ptr0  (ptr0Val),
    .ptr1  (ptr1Val),
    .acc   (accValue)
  );
endmodule

// File: rtl/bdm_checker.sv
module bdm_checker
  import bdm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] accValue,
  input logic              bothIndErr,
  input logic [DATA_W-1:0] ptr0,
  input logic              wrGo
);
  a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == '0);

  a_r7_void_pointer_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == IND0_ADDR && (ptr0 == IND0_ADDR || ptr0 == IND1_ADDR))
      |-> rdData == '0);

  a_r9_conflict_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    bothIndErr |-> !wrGo);

  a_r8_acc_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ACC_ADDR) |=> accValue == $past(wrData));

  a_r1_reset_clears_acc: assert property (@(posedge clk)
    !rstN |=> accValue == '0);
endmodule

bind bdm_top bdm_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .rdData    (rdData),
  .accValue  (accValue),
  .bothIndErr(bothIndErr),
  .ptr0      (ptr0Val),
  .wrGo      (strobe.wrGo)
);

// File: tb/bdm_top_tb_top.sv
`timescale 1ns/1ps
module bdm_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] rdAddr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] bankSel = '0;
  logic [7:0] rdData;
  logic [7:0] accValue;
  logic       bothIndErr;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;
  logic [7:0] refMem [768];

  always #5 clk = ~clk;

  bdm_top dut_i (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .bankSel(bankSel), .rdData(rdData),
    .accValue(accValue), .bothIndErr(bothIndErr)
  );

  function automatic bit isVirt(input logic [7:0] a);
    return a == 8'h00 || a == 8'h02;
  endfunction

  // Model index: bank*256 + address, or -1 when the pointer names 00H/02H.
  function automatic int refIdx(input logic [7:0] a, input logic [7:0] bs);
    logic [7:0] p;
    if (a == 8'h00) begin
      p = refMem[1];
      if (isVirt(p)) return -1;
      return int'(p);
    end
    if (a == 8'h02) begin
      p = refMem[3];
      if (isVirt(p)) return -1;
      if (p >= 8'h40 && bs == 8'h01) return 256 + int'(p);
      if (p >= 8'h40 && bs == 8'h02) return 512 + int'(p);
      return int'(p);
    end
    return int'(a);
  endfunction

  function automatic logic [7:0] refRead(input logic [7:0] a, input logic [7:0] bs);
    int i;
    i = refIdx(a, bs);
    return (i < 0) ? 8'h00 : refMem[i];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // One cycle: optional read checked combinationally, optional write, model updated.
  task automatic op(input bit rE, input logic [7:0] rA, input bit wE, input logic [7:0] wA,
                    input logic [7:0] wD, input logic [7:0] bs, input string tag);
    logic [7:0] expRd;
    bit         expErr;
    int         wi;
    @(negedge clk);
    rdEn = rE; rdAddr = rA; wrEn = wE; wrAddr = wA; wrData = wD; bankSel = bs;
    expRd  = rE ? refRead(rA, bs) : 8'h00;
    expErr = rE && wE && isVirt(rA) && isVirt(wA);
    wi     = refIdx(wA, bs);
    #1;
    chk(rdData == expRd, {tag, " rdData"}, rdData, expRd);
    chk(bothIndErr == expErr, {tag, " R9 flag"}, {7'b0, bothIndErr}, {7'b0, expErr});
    @(posedge clk);
    if (wE && !expErr && wi >= 0) refMem[wi] = wD;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    #1;
    chk(accValue == refMem[5], {tag, " R8 acc"}, accValue, refMem[5]);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [7:0] bs, input string tag);
    op(1'b0, 8'h00, 1'b1, a, d, bs, tag);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] bs, input string tag);
    op(1'b1, a, 1'b0, 8'h00, 8'h00, bs, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pick [8];
    logic [7:0] bsPick [5];
    for (int i = 0; i < 768; i++) refMem[i] = 8'h00;
    pick = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h3F, 8'h40, 8'hFF};
    bsPick = '{8'h00, 8'h01, 8'h02, 8'h03, 8'hFF};
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 chk(accValue == 8'h00, "R1 acc in reset", accValue, 8'h00);
    rstN = 1'b1;

    // R1: reset contents
    rd(8'h01, 8'h00, "R1");
    rd(8'h40, 8'h01, "R1");
    rd(8'hFF, 8'h02, "R1");
    // R10: no read strobe, data low
    wr(8'h30, 8'h5C, 8'h00, "R2");
    @(negedge clk); rdAddr = 8'h30; rdEn = 1'b0; #1;
    chk(rdData == 8'h00, "R10 idle read", rdData, 8'h00);
    // R2: direct ignores bank selector
    wr(8'h10, 8'hAA, 8'h01, "R2");
    rd(8'h10, 8'h02, "R2");
    wr(8'h80, 8'h11, 8'h02, "R2");
    rd(8'h80, 8'h01, "R2");
    // R3: first pointer
    wr(8'h01, 8'h80, 8'h00, "R3");
    wr(8'h00, 8'h5A, 8'h01, "R3");
    rd(8'h80, 8'h00, "R3");
    rd(8'h00, 8'h02, "R3");
    // R4: second pointer into shared window
    wr(8'h03, 8'h20, 8'h00, "R4");
    wr(8'h02, 8'h77, 8'h02, "R4");
    rd(8'h20, 8'h00, "R4");
    wr(8'h03, 8'h3F, 8'h00, "R4");
    wr(8'h02, 8'hC3, 8'h01, "R4");
    rd(8'h3F, 8'h00, "R4");
    // R5: upper window banks
    wr(8'h03, 8'h80, 8'h00, "R5");
    wr(8'h02, 8'hB1, 8'h01, "R5");
    wr(8'h02, 8'hB2, 8'h02, "R5");
    rd(8'h80, 8'h00, "R5");
    rd(8'h02, 8'h01, "R5");
    rd(8'h02, 8'h02, "R5");
    wr(8'h03, 8'h40, 8'h00, "R5");
    wr(8'h02, 8'hD4, 8'h01, "R5");
    rd(8'h40, 8'h00, "R5");
    rd(8'h02, 8'h01, "R5");
    // R6: other selector values fall back to bank 0
    wr(8'h03, 8'h80, 8'h00, "R6");
    rd(8'h02, 8'h03, "R6");
    rd(8'h02, 8'hFF, "R6");
    rd(8'h02, 8'h00, "R6");
    // R7: pointers holding forwarded addresses
    wr(8'h01, 8'h00, 8'h00, "R7");
    rd(8'h00, 8'h00, "R7");
    wr(8'h00, 8'h99, 8'h00, "R7");
    rd(8'h01, 8'h00, "R7");
    wr(8'h03, 8'h02, 8'h00, "R7");
    wr(8'h02, 8'h98, 8'h01, "R7");
    rd(8'h02, 8'h01, "R7");
    rd(8'h03, 8'h00, "R7");
    // R8: accumulator, direct and forwarded
    wr(8'h05, 8'h3C, 8'h00, "R8");
    wr(8'h01, 8'h05, 8'h00, "R8");
    wr(8'h00, 8'h4D, 8'h02, "R8");
    // R9: move naming both forwarded locations
    wr(8'h01, 8'h90, 8'h00, "R9");
    wr(8'h03, 8'h91, 8'h00, "R9");
    wr(8'h91, 8'h21, 8'h00, "R9");
    op(1'b1, 8'h00, 1'b1, 8'h02, 8'hEE, 8'h00, "R9");
    rd(8'h91, 8'h00, "R9");
    op(1'b1, 8'h00, 1'b1, 8'h91, 8'h22, 8'h00, "R9");
    rd(8'h91, 8'h00, "R9");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] ra, wa, bs;
      bit re, we;
      ra = ($urandom % 2) ? pick[$urandom % 8] : 8'($urandom);
      wa = ($urandom % 2) ? pick[$urandom % 8] : 8'($urandom);
      bs = bsPick[$urandom % 5];
      re = ($urandom % 4) != 0;
      we = ($urandom % 2) != 0;
      op(re, ra, we, wa, 8'($urandom), bs, "R2 R3 R4 R5 R6 R7 R9 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule